// File: doc/BRIEF.md
# Linked Descriptor Request Processor

This block takes memory requests from several clients, each of which owns a mailbox of three 32-bit words. A client loads words 1 and 2 as needed and then writes word 0, which starts the request. The engine serves one request at a time. It issues single reads, burst reads, burst writes and fills to a downstream external-memory port, one element per access. When it is done, it posts a done flag, a status code and any read data back to that client's mailbox outputs.

A list-start request makes the engine walk a chain of descriptors held in a local buffer memory. Each descriptor is either 4 or 8 words long. A short descriptor carries one ordinary request. A long descriptor carries a strided two-dimensional copy: every scan line is first read from external memory into the buffer, then written from the buffer to the destination, and after each line the source and destination addresses step by their own pitches. The chain is followed through link words until it reaches a zero link or hits the first error.

Top module: `desc_chain_engine`

## Requirements
- R1: Writing mailbox word 0 (select 0) clears that client's done flag and queues the request. When the request finishes, done is set, with status 0 on success.
- R2: Word 0 holds the request type in bits 31:28, the bank in bits 27:24 and the in-bank byte offset in bits 23:0. The external address is {bank, offset}, and address stepping wraps inside the bank. Type codes: 1/2/3 read 1/2/4 bytes, 4 burst read, 5 burst write, 6/7/8 fill with 1/2/4-byte elements, 9 list start.
- R3: A single read uses word 0 only. It returns the little-endian value zero-extended in the client's data output.
- R4: A fill writes the low bytes of word 1, count times, where word 2 gives the count. The address advances by the element size after each write.
- R5: A burst read copies word 2 / 4 longs from external memory to buffer words starting at word 1. A burst write copies the same amount in the opposite direction.
- R6: A request whose bank is not mapped by BANK_MASK finishes with status 1 and makes no external access. Bank 15 can never be mapped.
- R7: For a list start, word 0 bits BAW-1:0 give the buffer address of the first descriptor. A short descriptor is four words: request word 0, word 1, word 2, then a link word. A link of zero ends the chain.
- R8: A descriptor whose 4th word has bit 31 set is 8 words long. Its words are: source word 0, buffer address, bytes per line, destination {bank, offset} in bits 27:0, line count, source pitch, destination pitch, link.
- R9: A two-dimensional copy moves each line through the buffer. After each line the source advances by the source pitch and the destination by the destination pitch.
- R10: An unknown type gives status 2, and a list start inside a chain gives status 3. The chain stops at its first error, and no later descriptor executes.
- R11: When several clients are pending, the lowest-numbered client is served first.
- R12: In any cycle, at most one of the buffer port and the external port is accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mbx_wr | input | 1 | Mailbox word write strobe |
| mbx_cli | input | CW | Client whose mailbox is written |
| mbx_sel | input | 2 | Mailbox word select (0 starts the request) |
| mbx_wdata | input | 32 | Mailbox write data |
| cli_done | output | NCLI | Per-client completion flag |
| cli_status | output | NCLI*4 | Per-client status code |
| cli_data | output | NCLI*32 | Per-client single-read result |
| buf_en | output | 1 | Buffer memory access |
| buf_we | output | 1 | Buffer write (else read, data next cycle) |
| buf_addr | output | BAW | Buffer word address |
| buf_wdata | output | 32 | Buffer write data |
| buf_rdata | input | 32 | Buffer read data |
| ext_en | output | 1 | External access |
| ext_we | output | 1 | External write (else read, data next cycle) |
| ext_size | output | 2 | Element size: 0 byte, 1 half, 2 long |
| ext_addr | output | 28 | External byte address {bank, offset} |
| ext_wdata | output | 32 | External write data, low-aligned |
| ext_rdata | input | 32 | External read data, zero-extended |

## Verification
A wrong decode or stepping register shows up within a few cycles as misplaced or missing bytes in the modelled external memory. A wrong link or length flag shows up as a descriptor that runs when it should not, or one that is skipped. Faulty error handling shows at the ports as a wrong status code, or as external accesses that occur after the fault. A wrong arbitration state inverts which client's fill lands last in a shared region. Every one of these is visible by the time the affected client's done flag rises.

// File: rtl/dce_pkg.sv
package dce_pkg;
   localparam logic [3:0] RQ_RD8  = 4'd1;
   localparam logic [3:0] RQ_RD16 = 4'd2;
   localparam logic [3:0] RQ_RD32 = 4'd3;
   localparam logic [3:0] RQ_BRD  = 4'd4;
   localparam logic [3:0] RQ_BWR  = 4'd5;
   localparam logic [3:0] RQ_FL8  = 4'd6;
   localparam logic [3:0] RQ_FL16 = 4'd7;
   localparam logic [3:0] RQ_FL32 = 4'd8;
   localparam logic [3:0] RQ_LIST = 4'd9;

   localparam logic [3:0] ST_OK   = 4'd0;
   localparam logic [3:0] ST_BANK = 4'd1;
   localparam logic [3:0] ST_TYPE = 4'd2;
   localparam logic [3:0] ST_NEST = 4'd3;

   typedef enum logic [3:0] {
      S_IDLE, S_FA, S_FB, S_DEC, S_SRA, S_SRB, S_RA, S_RB,
      S_WA, S_WB, S_LINE, S_FILL, S_NEXT, S_FIN
   } eng_st_t;

   function automatic logic [23:0] elem_bytes(input logic [1:0] sz);
      case (sz)
         2'd0:    return 24'd1;
         2'd1:    return 24'd2;
         default: return 24'd4;
      endcase
   endfunction

   function automatic logic [27:0] step_in_bank(input logic [27:0] a, input logic [23:0] inc);
      return {a[27:24], a[23:0] + inc};
   endfunction
endpackage

// File: rtl/dce_arb.sv
module dce_arb #(
   parameter int NCLI = 2,
   localparam int CW = $clog2(NCLI)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCLI-1:0] pend,
   output logic            any,
   output logic [CW-1:0]   idx
);
   always_comb begin
      any = |pend;
      idx = '0;
      for (int i = NCLI - 1; i >= 0; i--)
         if (pend[i]) idx = CW'(i);
   end

   logic [NCLI-1:0] below;
   assign below = (NCLI'(1) << idx) - NCLI'(1);

   // R11: the chosen client is pending and no lower one is
   p_lowest_r11: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> (pend[idx] && ((pend & below) == '0)));
endmodule

// File: rtl/dce_mbox.sv
module dce_mbox #(
   parameter int NCLI = 2,
   localparam int CW = $clog2(NCLI)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [CW-1:0]      cli,
   input  logic [1:0]         sel,
   input  logic [31:0]        wdata,
   input  logic               take,
   input  logic [CW-1:0]      gnt,
   input  logic               fin,
   input  logic [CW-1:0]      fin_cli,
   input  logic [3:0]         fin_status,
   input  logic [31:0]        fin_data,
   output logic [NCLI-1:0]    pend,
   output logic [31:0]        g_w0,
   output logic [31:0]        g_w1,
   output logic [31:0]        g_w2,
   output logic [NCLI-1:0]    done,
   output logic [NCLI*4-1:0]  status_f,
   output logic [NCLI*32-1:0] data_f
);
   logic [NCLI*32-1:0] w0_f, w1_f, w2_f;

   for (genvar c = 0; c < NCLI; c++) begin : g_cli
      logic [31:0] w0_q, w1_q, w2_q, dat_q;
      logic [3:0]  st_q;
      logic        pend_q, done_q;
      logic        hit;
      assign hit = wr && (cli == CW'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            w0_q <= '0; w1_q <= '0; w2_q <= '0; dat_q <= '0;
            st_q <= '0; pend_q <= 1'b0; done_q <= 1'b0;
         end else begin
            if (take && gnt == CW'(c)) pend_q <= 1'b0;
            if (hit) begin
               case (sel)
                  2'd0: begin w0_q <= wdata; pend_q <= 1'b1; done_q <= 1'b0; end
                  2'd1: w1_q <= wdata;
                  2'd2: w2_q <= wdata;
                  default: ;
               endcase
            end
            if (fin && fin_cli == CW'(c)) begin
               done_q <= 1'b1;
               st_q   <= fin_status;
               dat_q  <= fin_data;
            end
         end
      end

      assign pend[c]             = pend_q;
      assign done[c]             = done_q;
      assign status_f[c*4 +: 4]  = st_q;
      assign data_f[c*32 +: 32]  = dat_q;
      assign w0_f[c*32 +: 32]    = w0_q;
      assign w1_f[c*32 +: 32]    = w1_q;
      assign w2_f[c*32 +: 32]    = w2_q;

      // R1, R11: a taken request leaves the queue on the next cycle
      p_take_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (take && gnt == CW'(c) && !(hit && sel == 2'd0)) |=> !pend_q);
      // R1: starting a request drops the done flag
      p_start_clears_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && sel == 2'd0 && !(fin && fin_cli == CW'(c))) |=> !done_q);
   end

   assign g_w0 = w0_f[gnt*32 +: 32];
   assign g_w1 = w1_f[gnt*32 +: 32];
   assign g_w2 = w2_f[gnt*32 +: 32];
endmodule

// File: rtl/dce_engine.sv
module dce_engine
   import dce_pkg::*;
#(
   parameter int          NCLI      = 2,
   parameter int          BAW       = 8,
   parameter logic [15:0] BANK_MASK = 16'h0003,
   localparam int CW = $clog2(NCLI)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_any,
   input  logic [CW-1:0]  req_cli,
   input  logic [31:0]    rw0,
   input  logic [31:0]    rw1,
   input  logic [31:0]    rw2,
   output logic           take,
   output logic           fin,
   output logic [CW-1:0]  fin_cli,
   output logic [3:0]     fin_status,
   output logic [31:0]    fin_data,
   output logic           buf_en,
   output logic           buf_we,
   output logic [BAW-1:0] buf_addr,
   output logic [31:0]    buf_wdata,
   input  logic [31:0]    buf_rdata,
   output logic           ext_en,
   output logic           ext_we,
   output logic [1:0]     ext_size,
   output logic [27:0]    ext_addr,
   output logic [31:0]    ext_wdata,
   input  logic [31:0]    ext_rdata
);
   eng_st_t        st;
   logic [31:0]    dw [8];
   logic [2:0]     k;
   logic [BAW-1:0] ptr, link, bbase;
   logic           inlist, rd_ph, wr_ph;
   logic [27:0]    src, dst;
   logic [31:0]    cnt, tot, lines, fdata, res_data;
   logic [23:0]    spitch, dpitch;
   logic [1:0]     sz;
   logic [3:0]     status;
   logic [CW-1:0]  cli_q;

   logic [3:0]  d_ty;
   logic        d_ext, d_bank_ok, d_xbank_ok;
   logic [23:0] woff;
   assign d_ty       = dw[0][31:28];
   assign d_ext      = inlist && dw[3][31];
   assign d_bank_ok  = BANK_MASK[dw[0][27:24]];
   assign d_xbank_ok = BANK_MASK[dw[3][27:24]];
   assign woff       = {cnt[21:0], 2'b00};

   assign take       = (st == S_IDLE) && req_any;
   assign fin        = (st == S_FIN);
   assign fin_cli    = cli_q;
   assign fin_status = status;
   assign fin_data   = res_data;

   always_comb begin
      buf_en = 1'b0; buf_we = 1'b0; buf_addr = ptr + BAW'(k); buf_wdata = ext_rdata;
      ext_en = 1'b0; ext_we = 1'b0; ext_size = 2'd2; ext_addr = src; ext_wdata = fdata;
      case (st)
         S_FA:   buf_en = 1'b1;
         S_SRA:  begin ext_en = 1'b1; ext_size = sz; end
         S_RA:   begin ext_en = 1'b1; ext_addr = step_in_bank(src, woff); end
         S_RB:   begin buf_en = 1'b1; buf_we = 1'b1; buf_addr = bbase + cnt[BAW-1:0]; end
         S_WA:   begin buf_en = 1'b1; buf_addr = bbase + cnt[BAW-1:0]; end
         S_WB:   begin ext_en = 1'b1; ext_we = 1'b1; ext_addr = step_in_bank(dst, woff);
                       ext_wdata = buf_rdata; end
         S_FILL: begin ext_en = 1'b1; ext_we = 1'b1; ext_size = sz; ext_addr = dst; end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; k <= '0; ptr <= '0; link <= '0; bbase <= '0;
         inlist <= 1'b0; rd_ph <= 1'b0; wr_ph <= 1'b0; src <= '0; dst <= '0;
         cnt <= '0; tot <= '0; lines <= '0; fdata <= '0; res_data <= '0;
         spitch <= '0; dpitch <= '0; sz <= '0; status <= ST_OK; cli_q <= '0;
         for (int i = 0; i < 8; i++) dw[i] <= '0;
      end else begin
         case (st)
            S_IDLE: if (req_any) begin
               cli_q <= req_cli; dw[0] <= rw0; dw[1] <= rw1; dw[2] <= rw2; dw[3] <= '0;
               inlist <= 1'b0; status <= ST_OK; res_data <= '0; st <= S_DEC;
            end
            S_FA: st <= S_FB;
            S_FB: begin
               dw[k] <= buf_rdata;
               if ((k == 3'd3 && !buf_rdata[31]) || k == 3'd7) begin
                  k <= '0; st <= S_DEC;
               end else begin
                  k <= k + 3'd1; st <= S_FA;
               end
            end
            S_DEC: begin
               cnt <= '0; src <= dw[0][27:0]; dst <= dw[0][27:0];
               bbase <= dw[1][BAW-1:0]; fdata <= dw[1];
               link <= d_ext ? dw[7][BAW-1:0] : dw[3][BAW-1:0];
               tot <= {2'b00, dw[2][31:2]}; lines <= 32'd1;
               if (d_ext) begin
                  if (!d_bank_ok || !d_xbank_ok) begin
                     status <= ST_BANK; st <= S_FIN;
                  end else begin
                     dst <= dw[3][27:0]; lines <= dw[4];
                     spitch <= dw[5][23:0]; dpitch <= dw[6][23:0];
                     rd_ph <= 1'b1; wr_ph <= 1'b1;
                     st <= (dw[4] == '0 || dw[2][31:2] == '0) ? S_NEXT : S_RA;
                  end
               end else if (d_ty == RQ_LIST) begin
                  if (inlist) begin
                     status <= ST_NEST; st <= S_FIN;
                  end else begin
                     inlist <= 1'b1; ptr <= dw[0][BAW-1:0]; k <= '0; st <= S_FA;
                  end
               end else if (d_ty >= RQ_RD8 && d_ty <= RQ_FL32) begin
                  if (!d_bank_ok) begin
                     status <= ST_BANK; st <= S_FIN;
                  end else if (d_ty <= RQ_RD32) begin
                     sz <= 2'(d_ty - RQ_RD8); st <= S_SRA;
                  end else if (d_ty == RQ_BRD) begin
                     rd_ph <= 1'b1; wr_ph <= 1'b0;
                     st <= (dw[2][31:2] == '0) ? S_NEXT : S_RA;
                  end else if (d_ty == RQ_BWR) begin
                     rd_ph <= 1'b0; wr_ph <= 1'b1;
                     st <= (dw[2][31:2] == '0) ? S_NEXT : S_WA;
                  end else begin
                     sz <= 2'(d_ty - RQ_FL8); tot <= dw[2];
                     st <= (dw[2] == '0) ? S_NEXT : S_FILL;
                  end
               end else begin
                  status <= ST_TYPE; st <= S_FIN;
               end
            end
            S_SRA: st <= S_SRB;
            S_SRB: begin
               case (sz)
                  2'd0:    res_data <= {24'd0, ext_rdata[7:0]};
                  2'd1:    res_data <= {16'd0, ext_rdata[15:0]};
                  default: res_data <= ext_rdata;
               endcase
               st <= S_NEXT;
            end
            S_RA: st <= S_RB;
            S_RB: if (cnt + 32'd1 == tot) begin
               cnt <= '0; st <= wr_ph ? S_WA : S_LINE;
            end else begin
               cnt <= cnt + 32'd1; st <= S_RA;
            end
            S_WA: st <= S_WB;
            S_WB: if (cnt + 32'd1 == tot) begin
               cnt <= '0; st <= S_LINE;
            end else begin
               cnt <= cnt + 32'd1; st <= S_WA;
            end
            S_LINE: if (lines == 32'd1) st <= S_NEXT;
            else begin
               lines <= lines - 32'd1;
               src <= step_in_bank(src, spitch);
               dst <= step_in_bank(dst, dpitch);
               st <= rd_ph ? S_RA : S_WA;
            end
            S_FILL: begin
               dst <= step_in_bank(dst, elem_bytes(sz));
               cnt <= cnt + 32'd1;
               if (cnt + 32'd1 == tot) st <= S_NEXT;
            end
            S_NEXT: if (inlist && link != '0) begin
               ptr <= link; k <= '0; st <= S_FA;
            end else st <= S_FIN;
            S_FIN: st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   // R12: the two memory ports are never driven in the same cycle
   p_one_port_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(buf_en && ext_en));
   // R6: every external access lands in a mapped bank
   p_bank_mapped_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ext_en |-> BANK_MASK[ext_addr[27:24]]);
   // R4: back-to-back fill writes step by the element size
   p_fill_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_FILL && $past(st) == S_FILL) |->
         ext_addr[23:0] == $past(ext_addr[23:0]) + elem_bytes($past(sz)));
   // R10: once a fault is recorded, no memory is touched
   p_halt_on_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (status != ST_OK) |-> (!ext_en && !buf_en));
   // R1: completion is a single-cycle pulse
   p_fin_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !fin);
endmodule

// File: rtl/desc_chain_engine.sv
module desc_chain_engine #(
   parameter int          NCLI      = 2,
   parameter int          BAW       = 8,
   parameter logic [15:0] BANK_MASK = 16'h0003,
   localparam int CW = $clog2(NCLI)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mbx_wr,
   input  logic [CW-1:0]      mbx_cli,
   input  logic [1:0]         mbx_sel,
   input  logic [31:0]        mbx_wdata,
   output logic [NCLI-1:0]    cli_done,
   output logic [NCLI*4-1:0]  cli_status,
   output logic [NCLI*32-1:0] cli_data,
   output logic               buf_en,
   output logic               buf_we,
   output logic [BAW-1:0]     buf_addr,
   output logic [31:0]        buf_wdata,
   input  logic [31:0]        buf_rdata,
   output logic               ext_en,
   output logic               ext_we,
   output logic [1:0]         ext_size,
   output logic [27:0]        ext_addr,
   output logic [31:0]        ext_wdata,
   input  logic [31:0]        ext_rdata
);
   if (NCLI < 2) begin : g_bad_ncli
      $error("NCLI must be at least 2");
   end
   if (BAW < 4 || BAW > 24) begin : g_bad_baw
      $error("BAW must be within 4..24");
   end
   if (BANK_MASK[15]) begin : g_bad_mask
      $error("bank 15 is reserved for control and cannot be mapped");
   end

   logic [NCLI-1:0] pend;
   logic            any, take, fin;
   logic [CW-1:0]   gnt, fin_cli;
   logic [31:0]     g_w0, g_w1, g_w2, fin_data;
   logic [3:0]      fin_status;

   dce_mbox #(.NCLI(NCLI)) u_mbox (
      .clk, .rst_n, .wr(mbx_wr), .cli(mbx_cli), .sel(mbx_sel), .wdata(mbx_wdata),
      .take, .gnt, .fin, .fin_cli, .fin_status, .fin_data,
      .pend, .g_w0, .g_w1, .g_w2,
      .done(cli_done), .status_f(cli_status), .data_f(cli_data)
   );

   dce_arb #(.NCLI(NCLI)) u_arb (
      .clk, .rst_n, .pend, .any, .idx(gnt)
   );

   dce_engine #(.NCLI(NCLI), .BAW(BAW), .BANK_MASK(BANK_MASK)) u_eng (
      .clk, .rst_n, .req_any(any), .req_cli(gnt), .rw0(g_w0), .rw1(g_w1), .rw2(g_w2),
      .take, .fin, .fin_cli, .fin_status, .fin_data,
      .buf_en, .buf_we, .buf_addr, .buf_wdata, .buf_rdata,
      .ext_en, .ext_we, .ext_size, .ext_addr, .ext_wdata, .ext_rdata
   );
endmodule

// File: tb/desc_chain_engine_test.sv
`timescale 1ns/1ps
module desc_chain_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mbx_wr = 1'b0;
   logic [0:0]  mbx_cli = '0;
   logic [1:0]  mbx_sel = '0;
   logic [31:0] mbx_wdata = '0;
   logic [1:0]  cli_done;
   logic [7:0]  cli_status;
   logic [63:0] cli_data;
   logic        buf_en, buf_we, ext_en, ext_we;
   logic [7:0]  buf_addr;
   logic [31:0] buf_wdata, ext_wdata;
   logic [31:0] buf_rdata = '0;
   logic [31:0] ext_rdata = '0;
   logic [1:0]  ext_size;
   logic [27:0] ext_addr;

   int vectors = 0, miscompares = 0, ext_cnt = 0;
   bit finished = 0;
   logic [7:0]  mem [8192];
   logic [31:0] bufm [256];

   always #2.5 clk = ~clk;

   desc_chain_engine uut (.*);

   function automatic int ix(input logic [27:0] a);
      return {a[24], a[11:0]};
   endfunction
   function automatic logic [7:0] pat(input int i);
      return 8'(i * 7 + 3);
   endfunction

   always @(posedge clk) begin
      if (ext_en) begin
         ext_cnt++;
         if (ext_we) begin
            for (int b = 0; b < (1 << ext_size); b++) mem[ix(ext_addr + 28'(b))] = ext_wdata[8*b +: 8];
         end else begin
            logic [31:0] v;
            v = '0;
            for (int b = 0; b < (1 << ext_size); b++) v[8*b +: 8] = mem[ix(ext_addr + 28'(b))];
            ext_rdata <= v;
         end
      end
      if (buf_en) begin
         if (buf_we) bufm[buf_addr] = buf_wdata;
         else buf_rdata <= bufm[buf_addr];
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic mb_write(input int c, input int s, input logic [31:0] d);
      @(negedge clk);
      mbx_wr = 1'b1; mbx_cli = 1'(c); mbx_sel = 2'(s); mbx_wdata = d;
      @(negedge clk);
      mbx_wr = 1'b0;
   endtask

   task automatic submit(input int c, input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
      mb_write(c, 1, w1);
      mb_write(c, 2, w2);
      mb_write(c, 0, w0);
   endtask

   task automatic wait_done(input int c);
      int n;
      n = 0;
      while (!cli_done[c] && n < 20000) begin @(negedge clk); n++; end
      chk("R1 done flag", 32'(cli_done[c]), 32'd1);
   endtask

   function automatic logic [31:0] stat(input int c);
      return 32'(cli_status[c*4 +: 4]);
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin : main
      int e0;
      logic [31:0] exp;
      for (int i = 0; i < 8192; i++) mem[i] = pat(i);
      for (int i = 0; i < 256; i++) bufm[i] = 32'hF000_0000 | i;
      repeat (3) @(negedge clk);
      chk("R1 reset done", 32'(cli_done), 32'd0);
      chk("R12 reset ports idle", {30'd0, buf_en, ext_en}, 32'd0);
      rst_n = 1'b1;

      // R3 single reads of each size in two banks (R2 address fields)
      for (int bk = 0; bk < 2; bk++)
         for (int t = 1; t <= 3; t++)
            for (int o = 0; o < 3; o++) begin
               logic [27:0] a;
               a = {4'(bk), 24'h000010 + 24'(o)};
               submit(0, {4'(t), a}, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
               wait_done(0);
               exp = '0;
               for (int b = 0; b < (1 << (t - 1)); b++) exp[8*b +: 8] = pat(ix(a + 28'(b)));
               chk("R3 single read data", cli_data[31:0], exp);
               chk("R1 read status", stat(0), 32'd0);
            end

      // R4 fill sweep over element size and count
      for (int t = 6; t <= 8; t++)
         for (int n = 1; n <= 3; n++) begin
            logic [27:0] base;
            int nb;
            base = {4'd0, 24'h000800 + 24'((t * 4 + n) * 32)};
            nb = 1 << (t - 6);
            submit(0, {4'(t), base}, 32'h8765_4321, 32'(n));
            wait_done(0);
            for (int e = 0; e < n; e++)
               for (int b = 0; b < nb; b++)
                  chk("R4 fill byte", 32'(mem[ix(base + 28'(e * nb + b))]), 32'(8'(32'h8765_4321 >> (8 * b))));
            chk("R4 fill end untouched", 32'(mem[ix(base + 28'(n * nb))]), 32'(pat(ix(base + 28'(n * nb)))));
         end

      // R5 burst write from buffer to bank 1
      for (int i = 0; i < 4; i++) bufm[200 + i] = 32'hA0B0_C000 + i;
      submit(1, 32'h5100_0900, 32'd200, 32'd16);
      wait_done(1);
      for (int i = 0; i < 16; i++)
         chk("R5 burst write byte", 32'(mem[ix(28'h100_0900 + 28'(i))]), 32'(8'((32'hA0B0_C000 + (i / 4)) >> (8 * (i % 4)))));

      // R5 burst read from bank 0 into buffer
      submit(1, 32'h4000_0100, 32'd210, 32'd12);
      wait_done(1);
      for (int w = 0; w < 3; w++) begin
         exp = '0;
         for (int b = 0; b < 4; b++) exp[8*b +: 8] = pat(ix(28'h000_0100 + 28'(4 * w + b)));
         chk("R5 burst read word", bufm[210 + w], exp);
      end
      chk("R5 burst read end untouched", bufm[213], 32'hF000_00D5);

      // R6 unmapped bank: status 1, no external access
      e0 = ext_cnt;
      submit(0, 32'h3200_0010, 32'd0, 32'd0);
      wait_done(0);
      chk("R6 bad bank status", stat(0), 32'd1);
      chk("R6 no external access", 32'(ext_cnt - e0), 32'd0);
      submit(0, 32'h6F00_0000, 32'h55, 32'd2);
      wait_done(0);
      chk("R6 bank 15 status", stat(0), 32'd1);

      // R10 unknown type
      e0 = ext_cnt;
      submit(0, 32'hC000_0000, 32'd0, 32'd0);
      wait_done(0);
      chk("R10 bad type status", stat(0), 32'd2);
      chk("R10 bad type no access", 32'(ext_cnt - e0), 32'd0);

      // R7 R8 R9 chain: extended 2D copy then short halfword fill
      bufm[16] = 32'h4000_0100; bufm[17] = 32'd100; bufm[18] = 32'd8;
      bufm[19] = 32'h8100_0040; bufm[20] = 32'd3;  bufm[21] = 32'd16;
      bufm[22] = 32'd32;        bufm[23] = 32'd32;
      bufm[32] = 32'h7100_0200; bufm[33] = 32'h0000_A55A; bufm[34] = 32'd5; bufm[35] = 32'd0;
      submit(0, 32'h9000_0010, 32'd0, 32'd0);
      wait_done(0);
      chk("R7 chain status", stat(0), 32'd0);
      for (int l = 0; l < 3; l++)
         for (int j = 0; j < 8; j++)
            chk("R9 copy byte", 32'(mem[ix(28'h100_0040 + 28'(32 * l + j))]), 32'(pat(ix(28'h000_0100 + 28'(16 * l + j)))));
      chk("R9 gap untouched", 32'(mem[ix(28'h100_0048)]), 32'(pat(ix(28'h100_0048))));
      for (int j = 0; j < 10; j++)
         chk("R7 linked fill byte", 32'(mem[ix(28'h100_0200 + 28'(j))]), (j % 2 == 0) ? 32'h5A : 32'hA5);
      chk("R7 linked fill end", 32'(mem[ix(28'h100_020A)]), 32'(pat(ix(28'h100_020A))));

      // R10 nested list start stops the chain
      bufm[48] = 32'h6000_0300; bufm[49] = 32'h11; bufm[50] = 32'd2; bufm[51] = 32'd56;
      bufm[56] = 32'h9000_0010; bufm[57] = 0;      bufm[58] = 0;     bufm[59] = 32'd64;
      bufm[64] = 32'h6000_0310; bufm[65] = 32'h22; bufm[66] = 32'd1; bufm[67] = 32'd0;
      submit(1, 32'h9000_0030, 32'd0, 32'd0);
      wait_done(1);
      chk("R10 nested status", stat(1), 32'd3);
      chk("R10 before nest ran", {mem[ix(28'h300)], mem[ix(28'h301)]}, 32'h1111);
      chk("R10 after nest skipped", 32'(mem[ix(28'h310)]), 32'(pat(ix(28'h310))));

      // R10 R6 bad bank inside a chain
      bufm[72] = 32'h6000_0320; bufm[73] = 32'h33; bufm[74] = 32'd1; bufm[75] = 32'd80;
      bufm[80] = 32'h6300_0000; bufm[81] = 32'h99; bufm[82] = 32'd1; bufm[83] = 32'd88;
      bufm[88] = 32'h6000_0330; bufm[89] = 32'h44; bufm[90] = 32'd1; bufm[91] = 32'd0;
      submit(1, 32'h9000_0048, 32'd0, 32'd0);
      wait_done(1);
      chk("R10 chain bank status", stat(1), 32'd1);
      chk("R10 first item ran", 32'(mem[ix(28'h320)]), 32'h33);
      chk("R10 later item skipped", 32'(mem[ix(28'h330)]), 32'(pat(ix(28'h330))));

      // R11 both clients queue behind a long fill; client 0 goes first
      submit(0, 32'h8000_0400, 32'hDEAD_BEEF, 32'd100);
      submit(1, 32'h6000_0600, 32'hB1, 32'd4);
      submit(0, 32'h6000_0600, 32'hC0, 32'd4);
      wait_done(1);
      wait_done(0);
      for (int j = 0; j < 4; j++)
         chk("R11 priority order", 32'(mem[ix(28'h600 + 28'(j))]), 32'hB1);
      chk("R4 long fill last word", {mem[ix(28'h58F)], mem[ix(28'h58E)], mem[ix(28'h58D)], mem[ix(28'h58C)]}, 32'hDEAD_BEEF);
      chk("R12 idle after work", {30'd0, buf_en, ext_en}, 32'd0);

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule